// File: doc/BRIEF.md
# Adaptation Spectral Gate

This block sits beside a receive equalizer and decides whether the recovered data is varied enough for tap adaptation to be trusted. Recovered bits enter a 14-position history register. On a snapshot strobe the history is frozen into a snapshot. Two programmable positions of that snapshot are compared, and the result moves a signed accumulator up when the two bits agree and down when they differ.

After a programmable number of snapshots, the window closes. The magnitude of the accumulator is compared with a programmable threshold. A small magnitude means the two positions are uncorrelated and the data looks random, so the enable flag is raised. A large magnitude, as with static or repeating data, drops the flag so that the late decision-feedback taps stop updating. The two positions are chosen to match the tap span being protected. A restart input discards the running window and begins a fresh one.

Top module: `adaptSpecGate`

## Requirements
- R1: After reset `adaptEn` is 0, the accumulator holds 0 and the snapshot count of the window is 0.
- R2: On each rising edge with `bitValid` high, `bitIn` enters history index 0 and every older bit moves up one index. Index 13 holds the oldest bit.
- R3: A rising edge with `snapStrobe` high copies the history into the snapshot as it stood before that edge. A bit entering at the same edge is not part of that snapshot.
- R4: At the edge after a snapshot, the accumulator steps +1 if snapshot positions `selA` and `selB` hold equal bits, and -1 otherwise. A selection value of 14 or 15 reads as bit 0.
- R5: The accumulator is 9-bit two's complement and clamps at +255 and -256 instead of wrapping.
- R6: When the step that completes `winLen` snapshots lands, `adaptEn` becomes 1 if the magnitude of the accumulator, including that step, is below `magThresh`, and 0 otherwise. At the same edge the accumulator and the count both return to 0. A `winLen` of 0 means 1024 snapshots.
- R7: The magnitude of -256 is taken as 256, so it is not below a threshold of 256.
- R8: A cycle with `winRestart` high clears the accumulator and the count at its edge. It also discards any step due at that edge and leaves `adaptEn` unchanged.
- R9: `adaptEn` changes only at the edge where a window completes. Changes to the threshold, the selections or the data between window ends have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| bitIn | input | 1 | Recovered data bit |
| bitValid | input | 1 | Shifts `bitIn` into the history |
| snapStrobe | input | 1 | Takes a snapshot of the history |
| winRestart | input | 1 | Discards the running window and starts a new one |
| selA | input | 4 | First compared snapshot index |
| selB | input | 4 | Second compared snapshot index |
| winLen | input | 10 | Snapshots per window; 0 selects 1024 |
| magThresh | input | 9 | Flag is raised when the magnitude is below this value |
| adaptEn | output | 1 | 1 lets the late equalizer taps adapt |

## Verification
A snapshot taken at edge T is scored at edge T+1. If that score closes the window, `adaptEn` shows the verdict after edge T+1. The bench drives inputs at falling edges. After the last strobe of a window it runs one idle cycle, then samples `adaptEn` at the following falling edge, which is after the flag register has settled. In the random scenarios, a cycle-stepped model of the requirements is compared against `adaptEn` at every falling edge. This also confirms that the flag never moves between window ends.

// File: rtl/adaptSpecGatePkg.sv
package adaptSpecGatePkg;

  // Strobes from the window control to the datapath, valid for one edge
  typedef struct packed {
    logic step;   // score the held snapshot at this edge
    logic judge;  // this step closes the window: update the flag
    logic clear;  // zero the accumulator at this edge
  } gateStrbT;

endpackage

// File: rtl/gateBitPick.sv
module gateBitPick #(
  parameter int HIST_LEN = 14,
  parameter int SEL_W    = 4
) (
  input  logic [HIST_LEN-1:0] vec,
  input  logic [SEL_W-1:0]    sel,
  output logic                bitOut
);

  // Out-of-range indices read as zero
  always_comb begin
    bitOut = 1'b0;
    for (int i = 0; i < HIST_LEN; i++) begin
      if (sel == SEL_W'(i)) bitOut = vec[i];
    end
  end

endmodule

// File: rtl/gateCtl.sv
module gateCtl
  import adaptSpecGatePkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             snapStrobe,
  input  logic             winRestart,
  input  logic [CNT_W-1:0] winLen,
  output gateStrbT         strb
);

  logic             pending;
  logic [CNT_W-1:0] snapCount;
  logic             lastSnap;

  // A snapshot taken at one edge is scored at the next
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= snapStrobe;
  end

  // winLen of 0 wraps to all ones, giving a 2**CNT_W window
  assign lastSnap = (snapCount == (winLen - CNT_W'(1)));

  always_comb begin
    strb.step  = pending & ~winRestart;
    strb.judge = strb.step & lastSnap;
    strb.clear = winRestart | strb.judge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          snapCount <= '0;
    else if (strb.clear) snapCount <= '0;
    else if (strb.step)  snapCount <= snapCount + CNT_W'(1);
  end

endmodule

// File: rtl/gateData.sv
module gateData
  import adaptSpecGatePkg::*;
#(
  parameter int HIST_LEN = 14,
  parameter int ACC_W    = 9,
  parameter int SEL_W    = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    bitIn,
  input  logic                    bitValid,
  input  logic                    snapStrobe,
  input  logic [SEL_W-1:0]        selA,
  input  logic [SEL_W-1:0]        selB,
  input  logic [ACC_W-1:0]        magThresh,
  input  gateStrbT                strb,
  output logic signed [ACC_W-1:0] accVal,
  output logic                    agree,
  output logic                    adaptEn
);

  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [HIST_LEN-1:0]     history;
  logic [HIST_LEN-1:0]     snapshot;
  logic [SEL_W-1:0]        selPair [2];
  logic [1:0]              pickBit;
  logic signed [ACC_W-1:0] accNext;
  logic [ACC_W-1:0]        magNext;

  // Index 0 is the newest bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         history <= '0;
    else if (bitValid) history <= {history[HIST_LEN-2:0], bitIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           snapshot <= '0;
    else if (snapStrobe) snapshot <= history;
  end

  assign selPair[0] = selA;
  assign selPair[1] = selB;

  for (genvar g = 0; g < 2; g++) begin : gPick
    gateBitPick #(
      .HIST_LEN(HIST_LEN),
      .SEL_W   (SEL_W)
    ) uPick (
      .vec   (snapshot),
      .sel   (selPair[g]),
      .bitOut(pickBit[g])
    );
  end

  assign agree = pickBit[0] ~^ pickBit[1];

  // Clamped up/down step
  always_comb begin
    if (agree) accNext = (accVal == ACC_MAX) ? accVal : accVal + ACC_W'(1);
    else       accNext = (accVal == ACC_MIN) ? accVal : accVal - ACC_W'(1);
  end

  // Unsigned magnitude: the most negative value maps to 2**(ACC_W-1)
  assign magNext = accNext[ACC_W-1] ? $unsigned(~accNext + ACC_W'(1)) : $unsigned(accNext);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           accVal <= '0;
    else if (strb.clear) accVal <= '0;
    else if (strb.step)  accVal <= accNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           adaptEn <= 1'b0;
    else if (strb.judge) adaptEn <= (magNext < magThresh);
  end

endmodule

// File: rtl/adaptSpecGate.sv
module adaptSpecGate
  import adaptSpecGatePkg::*;
#(
  parameter int HIST_LEN = 14,
  parameter int ACC_W    = 9,
  parameter int CNT_W    = 10,
  localparam int SEL_W   = $clog2(HIST_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitIn,
  input  logic             bitValid,
  input  logic             snapStrobe,
  input  logic             winRestart,
  input  logic [SEL_W-1:0] selA,
  input  logic [SEL_W-1:0] selB,
  input  logic [CNT_W-1:0] winLen,
  input  logic [ACC_W-1:0] magThresh,
  output logic             adaptEn
);

  gateStrbT                strb;
  logic signed [ACC_W-1:0] accVal;
  logic                    agree;

  gateCtl #(
    .CNT_W(CNT_W)
  ) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .snapStrobe(snapStrobe),
    .winRestart(winRestart),
    .winLen    (winLen),
    .strb      (strb)
  );

  gateData #(
    .HIST_LEN(HIST_LEN),
    .ACC_W   (ACC_W),
    .SEL_W   (SEL_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .bitIn     (bitIn),
    .bitValid  (bitValid),
    .snapStrobe(snapStrobe),
    .selA      (selA),
    .selB      (selB),
    .magThresh (magThresh),
    .strb      (strb),
    .accVal    (accVal),
    .agree     (agree),
    .adaptEn   (adaptEn)
  );

endmodule

// File: rtl/adaptSpecGateChk.sv
module adaptSpecGateChk
  import adaptSpecGatePkg::*;
#(
  parameter int ACC_W = 9
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    winRestart,
  input logic                    adaptEn,
  input gateStrbT                strb,
  input logic signed [ACC_W-1:0] accVal,
  input logic                    agree
);

  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  // R1
  reset_flag_chk: assert property (@(posedge clk) !rstN |-> !adaptEn);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.judge |=> $stable(adaptEn));

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    winRestart |=> accVal == '0);

  // R6
  judge_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.judge |=> accVal == '0);

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && !strb.clear && agree && accVal != ACC_MAX |=> accVal == $past(accVal) + ACC_W'(1));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && !strb.clear && !agree && accVal != ACC_MIN |=> accVal == $past(accVal) - ACC_W'(1));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step && !strb.clear |=> $stable(accVal));

  // R5
  sat_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && !strb.clear && agree && accVal == ACC_MAX |=> accVal == ACC_MAX);

  // R5
  sat_bot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && !strb.clear && !agree && accVal == ACC_MIN |=> accVal == ACC_MIN);

endmodule

bind adaptSpecGate adaptSpecGateChk #(.ACC_W(ACC_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .winRestart(winRestart),
  .adaptEn   (adaptEn),
  .strb      (strb),
  .accVal    (accVal),
  .agree     (agree)
);

// File: tb/adaptSpecGate_test.sv
module adaptSpecGate_test;

  localparam int CLK_PERIOD = 10;
  localparam int HIST_LEN   = 14;
  localparam int ACC_W      = 9;
  localparam int CNT_W      = 10;
  localparam int SEL_W      = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitIn = 1'b0, bitValid = 1'b0, snapStrobe = 1'b0, winRestart = 1'b0;
  logic [SEL_W-1:0] selA = '0, selB = '0;
  logic [CNT_W-1:0] winLen = '0;
  logic [ACC_W-1:0] magThresh = '0;
  logic adaptEn;

  int checks = 0;
  int fails  = 0;

  // Requirement model state
  logic [HIST_LEN-1:0] mHist = '0, mSnap = '0;
  logic mPend = 1'b0, mFlag = 1'b0;
  int mAcc = 0, mCnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  adaptSpecGate uut (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .snapStrobe(snapStrobe), .winRestart(winRestart), .selA(selA), .selB(selB),
    .winLen(winLen), .magThresh(magThresh), .adaptEn(adaptEn)
  );

  function automatic logic pick(input logic [HIST_LEN-1:0] v, input int s);
    return (s < HIST_LEN) ? v[s] : 1'b0;
  endfunction

  function automatic logic nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // Drive one cycle from a falling edge to the next, advancing the model at the rising edge
  task automatic tick(input logic b, input logic v, input logic s, input logic r);
    int lenEff;
    int mag;
    bitIn = b; bitValid = v; snapStrobe = s; winRestart = r;
    @(posedge clk);
    if (r) begin
      mAcc = 0; mCnt = 0;
    end else if (mPend) begin
      if (pick(mSnap, int'(selA)) == pick(mSnap, int'(selB))) begin
        if (mAcc < 255) mAcc++;
      end else if (mAcc > -256) mAcc--;
      mCnt++;
      lenEff = (winLen == '0) ? 1024 : int'(winLen);
      if (mCnt == lenEff) begin
        mag = (mAcc < 0) ? -mAcc : mAcc;
        mFlag = (mag < int'(magThresh));
        mAcc = 0; mCnt = 0;
      end
    end
    mPend = s;
    if (s) mSnap = mHist;
    if (v) mHist = {mHist[HIST_LEN-2:0], b};
    @(negedge clk);
  endtask

  task automatic idle();
    tick(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic chk(input string tag, input logic exp);
    checks++;
    if (adaptEn !== exp) begin
      fails++;
      $display("FAIL %s: adaptEn=%b expected %b", tag, adaptEn, exp);
    end
  endtask

  task automatic cfg(input int a, input int b, input int len, input int th);
    selA = SEL_W'(a); selB = SEL_W'(b); winLen = CNT_W'(len); magThresh = ACC_W'(th);
  endtask

  // mode 0: ones, 1: alternating, 2: pseudo-random
  function automatic logic patBit(input int mode);
    if (mode == 0) return 1'b1;
    if (mode == 1) return ~mHist[0];
    return nextRand();
  endfunction

  task automatic fill(input int mode);
    for (int i = 0; i < HIST_LEN; i++) tick(patBit(mode), 1'b1, 1'b0, 1'b0);
  endtask

  task automatic strobeRun(input int n, input int mode);
    for (int i = 0; i < n; i++) tick(patBit(mode), 1'b1, 1'b1, 1'b0);
  endtask

  task automatic testReset();
    chk("R1 flag low after reset", 1'b0);
    fill(0);
    cfg(0, 1, 1, 2);
    strobeRun(1, 0); idle();
    chk("R1 accumulator starts at zero", 1'b1);
  endtask

  task automatic testThreshold();
    cfg(0, 1, 10, 10);
    strobeRun(10, 0); idle();
    chk("R6 magnitude equal to threshold", 1'b0);
    cfg(0, 1, 10, 11);
    strobeRun(10, 0); idle();
    chk("R6 magnitude below threshold", 1'b1);
  endtask

  task automatic testSnapTiming();
    fill(3'd1 == 3'd1 ? 0 : 0);
    for (int i = 0; i < HIST_LEN; i++) tick(1'b0, 1'b1, 1'b0, 1'b0);
    cfg(0, 1, 2, 1);
    tick(1'b1, 1'b1, 1'b1, 1'b0);
    tick(1'b0, 1'b1, 1'b1, 1'b0);
    idle();
    chk("R3 snapshot excludes same-edge bit", 1'b1);
  endtask

  task automatic testSaturation();
    fill(0);
    cfg(0, 1, 300, 255);
    strobeRun(300, 0); idle();
    chk("R5 positive clamp, 255 not below 255", 1'b0);
    cfg(0, 1, 300, 256);
    strobeRun(300, 0); idle();
    chk("R5 positive clamp, 255 below 256", 1'b1);
    fill(1);
    cfg(0, 1, 300, 256);
    strobeRun(300, 1); idle();
    chk("R7 magnitude of -256 not below 256", 1'b0);
    cfg(0, 1, 300, 257);
    strobeRun(300, 1); idle();
    chk("R5 negative clamp, 256 below 257", 1'b1);
  endtask

  task automatic testRestart();
    fill(0);
    cfg(0, 1, 2, 1);
    strobeRun(2, 0); idle();
    chk("R6 static data freezes", 1'b0);
    cfg(0, 1, 6, 7);
    strobeRun(5, 0);
    tick(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R8 flag kept across restart", 1'b0);
    strobeRun(5, 0); idle();
    chk("R8 count restarted", 1'b0);
    strobeRun(1, 0); idle();
    chk("R8 full window after restart", 1'b1);
  endtask

  task automatic testHold();
    fill(2);
    cfg(0, 1, 20, 3);
    strobeRun(19, 2); idle();
    chk("R9 flag held mid-window", 1'b1);
    magThresh = '0;
    idle();
    chk("R9 threshold change alone", 1'b1);
    strobeRun(1, 2); idle();
    chk("R6 zero threshold never enables", 1'b0);
  endtask

  task automatic testRandom();
    int pa [5] = '{0, 3, 5, 13, 1};
    int pb [5] = '{13, 7, 5, 2, 14};
    for (int p = 0; p < 5; p++) begin
      tick(1'b0, 1'b0, 1'b0, 1'b1);
      cfg(pa[p], pb[p], 32, 9);
      for (int i = 0; i < 120; i++) begin
        tick(nextRand(), nextRand() | nextRand(), nextRand() | nextRand(), 1'b0);
        chk($sformatf("R2 R4 random pair %0d,%0d", pa[p], pb[p]), mFlag);
      end
    end
    idle();
    tick(1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testLongWindow();
    cfg(0, 0, 1, 0);
    strobeRun(1, 0); idle();
    chk("R6 reset flag before long window", 1'b0);
    fill(0);
    cfg(0, 1, 0, 300);
    strobeRun(1023, 0); idle();
    chk("R6 zero length still open at 1023", 1'b0);
    strobeRun(1, 0); idle();
    chk("R6 zero length closes at 1024", 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testThreshold();
    testSnapTiming();
    testSaturation();
    testRestart();
    testHold();
    testRandom();
    testLongWindow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule